// File: doc/BRIEF.md
# Adaptive In-Flight Instruction Limiter

This block sits beside the fetch stage of an out-of-order core and gates fetch to save front-end energy. It keeps a running count of instructions that have been fetched but not yet committed, and it raises a registered stall request whenever that count is above a cap. The cap is not fixed by software. The block finds it on its own, one measurement interval at a time.

Time is split into intervals, and each interval closes once a parameterised number of instructions has committed. A search starts with one interval in which the cap sits at the window size, so fetch is effectively unconstrained. The IPC of that interval becomes the reference. The cap then drops to a small starting value and rises by a fixed step at the end of every interval whose IPC falls short of the reference by more than a tolerance. The first cap whose interval keeps the loss within tolerance is held, and that interval's IPC becomes a baseline. While the cap is held, each interval's IPC is compared with the baseline. If it moves further than a noise margin in either direction, a new search begins. IPC ratios are compared by cross-multiplying committed counts and cycle counts, so the block needs no divider.

Top module: `fetch_cap_tuner`

## Requirements
- R1: Each cycle the in-flight count grows by the fetch input and shrinks by the commit input, with both applied together at the same clock edge.
- R2: The stall output is registered. After a clock edge it is 1 exactly when the in-flight count produced by that edge is strictly greater than the cap produced by that edge.
- R3: While synchronous reset is high, and on the first cycle after it, the cap reads WINDOW, the stall output is 0 and the in-flight count is 0. A reference interval then begins.
- R4: An interval closes on the edge where the commits gathered in it, including that cycle's commit input, reach INTERVAL. The cycles counted include that closing cycle. The cap changes only on a closing edge.
- R5: After a reference interval closes, the cap becomes INIT_LIMIT and the measured pair (commits, cycles) is kept as the reference.
- R6: During a search, a closing interval passes when commits_m * cycles_ref * 256 >= commits_ref * cycles_m * (256 - tol), where tol is the 8-bit tolerance input in units of 1/256. A pass holds the current cap and keeps that interval's pair as the baseline. A fail raises the cap by STEP.
- R7: The cap never exceeds WINDOW. A raise that would pass WINDOW sets the cap to WINDOW, and a search interval that closes with the cap already at WINDOW holds the cap whatever the IPC.
- R8: While the cap is held, an interval leaves the held state, setting the cap to WINDOW and starting a reference interval, when its IPC is below baseline*(256 - noise)/256 or above baseline*(256 + noise)/256. Both comparisons are cross-multiplied, and noise is the 8-bit margin input in units of 1/256.
- R9: While the cap is held, an interval whose IPC lies within the noise margin leaves the cap unchanged.
- R10: A commit input larger than the in-flight count plus the fetch input clamps the count to 0 and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_cnt_i | input | FETCH_W | Instructions fetched this cycle |
| commit_cnt_i | input | COMMIT_W | Instructions committed this cycle |
| tol_frac_i | input | 8 | Allowed IPC loss during a search, in 1/256 units |
| noise_frac_i | input | 8 | Allowed IPC drift while held, in 1/256 units |
| fetch_stall_o | output | 1 | Registered fetch inhibit request |
| limit_o | output | LIM_W | Current in-flight cap |

## Verification
A corrupted in-flight count shows up on the stall output on the very next edge. It appears when a count that should sit at or just above the cap gives the wrong stall value, for example after a commit burst that should have clamped the count to zero. A fault in the interval meter, the comparator or the phase register stays hidden until an interval closes. It then shows on limit_o at that edge as a missed or extra step, a hold at the wrong cap, or a missed return to WINDOW. Every check therefore compares both outputs on every cycle against a cycle-accurate model, and the bench adds explicit checks at the closing edges where the cap must settle, saturate, hold or restart.

// File: rtl/fetch_cap_pkg.sv
package fetch_cap_pkg;
  // tuning phase of the cap search
  typedef enum logic [1:0] {
    PH_REF    = 2'd0,  // reference interval, cap at window size
    PH_SEARCH = 2'd1,  // stepping the cap upward
    PH_HOLD   = 2'd2   // cap frozen, watching for drift
  } phase_e;

  localparam int FRAC_W = 8;
  localparam int FRAC_ONE = 1 << FRAC_W;
endpackage

// File: rtl/inflight_counter.sv
module inflight_counter #(
  parameter int FETCH_W  = 4,
  parameter int COMMIT_W = 4,
  parameter int CNT_W    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FETCH_W-1:0]  fetch_i,
  input  logic [COMMIT_W-1:0] commit_i,
  output logic [CNT_W-1:0]    cnt_d,
  output logic [CNT_W-1:0]    cnt_q
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [SUM_W-1:0] grown;
  logic [SUM_W-1:0] drain;

  always_comb begin
    grown = SUM_W'(cnt_q) + SUM_W'(fetch_i);
    drain = SUM_W'(commit_i);
    if (drain > grown)
      cnt_d = '0;
    else if ((grown - drain) > CNT_MAX)
      cnt_d = CNT_MAX[CNT_W-1:0];
    else
      cnt_d = CNT_W'(grown - drain);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/interval_meter.sv
module interval_meter #(
  parameter int INTERVAL = 100000,
  parameter int COMMIT_W = 4,
  parameter int CW       = 18,
  parameter int YW       = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COMMIT_W-1:0] commit_i,
  output logic                done_o,
  output logic [CW-1:0]       meas_c_o,
  output logic [YW-1:0]       meas_y_o
);
  logic [CW-1:0] acc_q;
  logic [YW-1:0] cyc_q;
  logic [CW-1:0] acc_n;
  logic [YW-1:0] cyc_n;

  always_comb begin
    acc_n    = acc_q + CW'(commit_i);
    cyc_n    = (cyc_q == '1) ? cyc_q : cyc_q + YW'(1);
    done_o   = (acc_n >= CW'(INTERVAL));
    meas_c_o = acc_n;
    meas_y_o = cyc_n;
  end

  always_ff @(posedge clk) begin
    if (rst || done_o) begin
      acc_q <= '0;
      cyc_q <= '0;
    end else begin
      acc_q <= acc_n;
      cyc_q <= cyc_n;
    end
  end
endmodule

// File: rtl/ipc_compare.sv
module ipc_compare
  import fetch_cap_pkg::*;
#(
  parameter int CW = 18,
  parameter int YW = 24
) (
  input  logic [CW-1:0]     c_m,
  input  logic [YW-1:0]     y_m,
  input  logic [CW-1:0]     c_b,
  input  logic [YW-1:0]     y_b,
  input  logic [FRAC_W-1:0] frac,
  output logic              at_least_low,
  output logic              above_high
);
  localparam int PW = CW + YW + FRAC_W + 2;

  logic [PW-1:0] meas_side;
  logic [PW-1:0] base_side;
  logic [PW-1:0] low_bound;
  logic [PW-1:0] high_bound;

  always_comb begin
    meas_side  = (PW'(c_m) * PW'(y_b)) << FRAC_W;
    base_side  = PW'(c_b) * PW'(y_m);
    low_bound  = base_side * (PW'(FRAC_ONE) - PW'(frac));
    high_bound = base_side * (PW'(FRAC_ONE) + PW'(frac));
    at_least_low = (meas_side >= low_bound);
    above_high   = (meas_side > high_bound);
  end
endmodule

// File: rtl/limit_tuner.sv
module limit_tuner
  import fetch_cap_pkg::*;
#(
  parameter int WINDOW     = 128,
  parameter int INIT_LIMIT = 32,
  parameter int STEP       = 16,
  parameter int LIM_W      = 8,
  parameter int CW         = 18,
  parameter int YW         = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [CW-1:0]     meas_c_i,
  input  logic [YW-1:0]     meas_y_i,
  input  logic              pass_low_i,
  input  logic              over_high_i,
  output logic [CW-1:0]     base_c_o,
  output logic [YW-1:0]     base_y_o,
  output logic              holding_o,
  output logic [LIM_W-1:0]  limit_d,
  output logic [LIM_W-1:0]  limit_q
);
  localparam logic [LIM_W:0] WIN_X = (LIM_W+1)'(WINDOW);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] base_c_q, base_c_d;
  logic [YW-1:0] base_y_q, base_y_d;
  logic [LIM_W:0] raised;

  always_comb begin
    phase_d  = phase_q;
    limit_d  = limit_q;
    base_c_d = base_c_q;
    base_y_d = base_y_q;
    raised   = (LIM_W+1)'(limit_q) + (LIM_W+1)'(STEP);
    if (raised > WIN_X) raised = WIN_X;
    if (done_i) begin
      unique case (phase_q)
        PH_REF: begin
          phase_d  = PH_SEARCH;
          limit_d  = LIM_W'(INIT_LIMIT);
          base_c_d = meas_c_i;
          base_y_d = meas_y_i;
        end
        PH_SEARCH: begin
          if (pass_low_i || ((LIM_W+1)'(limit_q) >= WIN_X)) begin
            phase_d  = PH_HOLD;
            base_c_d = meas_c_i;
            base_y_d = meas_y_i;
          end else begin
            limit_d = LIM_W'(raised);
          end
        end
        default: begin
          if (!pass_low_i || over_high_i) begin
            phase_d = PH_REF;
            limit_d = LIM_W'(WINDOW);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_REF;
      limit_q  <= LIM_W'(WINDOW);
      base_c_q <= '0;
      base_y_q <= '0;
    end else begin
      phase_q  <= phase_d;
      limit_q  <= limit_d;
      base_c_q <= base_c_d;
      base_y_q <= base_y_d;
    end
  end

  assign base_c_o  = base_c_q;
  assign base_y_o  = base_y_q;
  assign holding_o = (phase_q == PH_HOLD);
endmodule

// File: rtl/fetch_cap_tuner.sv
module fetch_cap_tuner
  import fetch_cap_pkg::*;
#(
  parameter int FETCH_W    = 4,
  parameter int COMMIT_W   = 4,
  parameter int WINDOW     = 128,
  parameter int INIT_LIMIT = 32,
  parameter int STEP       = 16,
  parameter int INTERVAL   = 100000,
  parameter int YW         = 24,
  localparam int LIM_W     = $clog2(WINDOW + 1),
  localparam int CNT_W     = $clog2(WINDOW + (1 << FETCH_W)) + 1,
  localparam int CW        = $clog2(INTERVAL + (1 << COMMIT_W)) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FETCH_W-1:0]  fetch_cnt_i,
  input  logic [COMMIT_W-1:0] commit_cnt_i,
  input  logic [7:0]          tol_frac_i,
  input  logic [7:0]          noise_frac_i,
  output logic                fetch_stall_o,
  output logic [LIM_W-1:0]    limit_o
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             iv_done;
  logic [CW-1:0]    meas_c, base_c;
  logic [YW-1:0]    meas_y, base_y;
  logic             holding, pass_low, over_high;
  logic [7:0]       sel_frac;
  logic [LIM_W-1:0] limit_d, limit_q;
  logic             stall_q;

  inflight_counter #(
    .FETCH_W(FETCH_W), .COMMIT_W(COMMIT_W), .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst(rst), .fetch_i(fetch_cnt_i), .commit_i(commit_cnt_i),
    .cnt_d(cnt_d), .cnt_q(cnt_q)
  );

  interval_meter #(
    .INTERVAL(INTERVAL), .COMMIT_W(COMMIT_W), .CW(CW), .YW(YW)
  ) u_meter (
    .clk(clk), .rst(rst), .commit_i(commit_cnt_i),
    .done_o(iv_done), .meas_c_o(meas_c), .meas_y_o(meas_y)
  );

  assign sel_frac = holding ? noise_frac_i : tol_frac_i;

  ipc_compare #(.CW(CW), .YW(YW)) u_cmp (
    .c_m(meas_c), .y_m(meas_y), .c_b(base_c), .y_b(base_y),
    .frac(sel_frac), .at_least_low(pass_low), .above_high(over_high)
  );

  limit_tuner #(
    .WINDOW(WINDOW), .INIT_LIMIT(INIT_LIMIT), .STEP(STEP),
    .LIM_W(LIM_W), .CW(CW), .YW(YW)
  ) u_tune (
    .clk(clk), .rst(rst), .done_i(iv_done),
    .meas_c_i(meas_c), .meas_y_i(meas_y),
    .pass_low_i(pass_low), .over_high_i(over_high),
    .base_c_o(base_c), .base_y_o(base_y), .holding_o(holding),
    .limit_d(limit_d), .limit_q(limit_q)
  );

  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= ((CNT_W+1)'(cnt_d) > (CNT_W+1)'(limit_d));
  end

  assign fetch_stall_o = stall_q;
  assign limit_o       = limit_q;
endmodule

// File: rtl/fetch_cap_tuner_chk.sv
module fetch_cap_tuner_chk #(
  parameter int WINDOW     = 128,
  parameter int INIT_LIMIT = 32,
  parameter int STEP       = 16,
  parameter int LIM_W      = 8,
  parameter int CNT_W      = 9,
  parameter int COMMIT_W   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [CNT_W-1:0]    count_q,
  input logic [LIM_W-1:0]    limit_o,
  input logic                stall,
  input logic                iv_done,
  input logic [COMMIT_W-1:0] commit_i
);
  // R1: without commits the in-flight count cannot shrink
  p_count_nodrop_r1: assert property (@(posedge clk) disable iff (rst)
    (commit_i == '0) |=> (count_q >= $past(count_q)));

  // R2: registered stall agrees with the count and cap registers
  p_stall_rel_r2: assert property (@(posedge clk) disable iff (rst)
    stall == (32'(count_q) > 32'(limit_o)));

  // R3: first cycle after reset
  p_reset_state_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (32'(limit_o) == WINDOW && !stall && count_q == '0));

  // R4: cap moves only on a closing edge
  p_limit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !iv_done |=> $stable(limit_o));

  // R6: a closing edge holds, steps by STEP, or returns to WINDOW
  p_limit_move_r6: assert property (@(posedge clk) disable iff (rst)
    iv_done |=> (limit_o == $past(limit_o)
                 || 32'(limit_o) == 32'($past(limit_o)) + STEP
                 || 32'(limit_o) == WINDOW
                 || 32'(limit_o) == INIT_LIMIT));

  // R7: cap stays within its range
  p_limit_range_r7: assert property (@(posedge clk) disable iff (rst)
    (32'(limit_o) <= WINDOW && 32'(limit_o) >= INIT_LIMIT));
endmodule

bind fetch_cap_tuner fetch_cap_tuner_chk #(
  .WINDOW(WINDOW), .INIT_LIMIT(INIT_LIMIT), .STEP(STEP),
  .LIM_W(LIM_W), .CNT_W(CNT_W), .COMMIT_W(COMMIT_W)
) chk_i (
  .clk(clk), .rst(rst), .count_q(cnt_q), .limit_o(limit_o),
  .stall(fetch_stall_o), .iv_done(iv_done), .commit_i(commit_cnt_i)
);

// File: tb/fetch_cap_tuner_tb_top.sv
module fetch_cap_tuner_tb_top;
  localparam int FETCH_W  = 4;
  localparam int COMMIT_W = 4;
  localparam int WINDOW   = 128;
  localparam int INIT     = 32;
  localparam int STEP     = 16;
  localparam int INTERVAL = 32;
  localparam int LIM_W    = $clog2(WINDOW + 1);
  localparam int TOL      = 26;
  localparam int NOISE    = 26;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [FETCH_W-1:0]  fetch_cnt = '0;
  logic [COMMIT_W-1:0] commit_cnt = '0;
  logic                stall;
  logic [LIM_W-1:0]    limit;

  always #5 clk = ~clk;

  fetch_cap_tuner #(
    .FETCH_W(FETCH_W), .COMMIT_W(COMMIT_W), .WINDOW(WINDOW),
    .INIT_LIMIT(INIT), .STEP(STEP), .INTERVAL(INTERVAL)
  ) dut_i (
    .clk(clk), .rst(rst), .fetch_cnt_i(fetch_cnt), .commit_cnt_i(commit_cnt),
    .tol_frac_i(8'(TOL)), .noise_frac_i(8'(NOISE)),
    .fetch_stall_o(stall), .limit_o(limit)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state (phase: 0 reference, 1 search, 2 hold)
  int m_cnt, m_limit, m_phase, m_acc, m_cyc, m_stall;
  longint m_bc, m_by;

  bit    exp_stall_q[$];
  int    exp_limit_q[$];
  string exp_tag_q[$];

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_limit = WINDOW; m_phase = 0; m_acc = 0; m_cyc = 0;
    m_stall = 0; m_bc = 0; m_by = 0;
  endtask

  // one cycle of the model from the requirements
  task automatic model_step(input int f, input int c);
    int sum, acc_n, cyc_n;
    bit done, pass, over;
    longint lhs, base;
    sum = m_cnt + f;
    m_cnt = (c > sum) ? 0 : sum - c;                     // R1, R10
    acc_n = m_acc + c;
    cyc_n = m_cyc + 1;
    done = (acc_n >= INTERVAL);                          // R4
    lhs  = longint'(acc_n) * m_by * 256;
    base = m_bc * longint'(cyc_n);
    pass = lhs >= base * (256 - ((m_phase == 2) ? NOISE : TOL));
    over = lhs >  base * (256 + NOISE);
    if (done) begin
      case (m_phase)
        0: begin m_phase = 1; m_limit = INIT; m_bc = acc_n; m_by = cyc_n; end // R5
        1: begin
          if (pass || m_limit >= WINDOW) begin                              // R6, R7
            m_phase = 2; m_bc = acc_n; m_by = cyc_n;
          end else begin
            m_limit = (m_limit + STEP > WINDOW) ? WINDOW : m_limit + STEP;
          end
        end
        default: if (!pass || over) begin m_phase = 0; m_limit = WINDOW; end // R8
      endcase
      m_acc = 0; m_cyc = 0;
    end else begin
      m_acc = acc_n; m_cyc = cyc_n;
    end
    m_stall = (m_cnt > m_limit) ? 1 : 0;                 // R2
  endtask

  // driver: apply one cycle and push the expected outputs
  task automatic apply(input int f, input int c, input string tag);
    @(negedge clk);
    fetch_cnt  = FETCH_W'(f);
    commit_cnt = COMMIT_W'(c);
    model_step(f, c);
    exp_stall_q.push_back(m_stall[0]);
    exp_limit_q.push_back(m_limit);
    exp_tag_q.push_back(tag);
  endtask

  // stimulus policy: commit rate depends on mode and model phase or cap
  task automatic step(input int mode, input string tag);
    int rate, f, c;
    case (mode)
      1: rate = (m_limit >= 64) ? 4 : 2;
      2: rate = 1;
      default: rate = (m_phase == 0) ? 4 : 2;
    endcase
    f = m_stall ? 0 : 6;
    c = (rate > m_cnt) ? m_cnt : rate;
    apply(f, c, tag);
  endtask

  // monitor: pop and compare after every edge
  always @(posedge clk) begin
    #1;
    if (exp_stall_q.size() > 0) begin
      bit es; int el; string t;
      es = exp_stall_q.pop_front();
      el = exp_limit_q.pop_front();
      t  = exp_tag_q.pop_front();
      check({"R2 stall ", t}, int'(stall), int'(es));
      check({"limit ", t}, int'(limit), el);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fetch_cnt = '0; commit_cnt = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic settle_read();
    @(posedge clk); #2;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reset limit", int'(limit), WINDOW);
    check("R3 reset stall", int'(stall), 0);

    // R10: commit burst larger than count clamps at zero
    apply(3, 0, "R1 grow");
    apply(0, 10, "R10 clamp");
    for (int i = 0; i < 8; i++) apply(15, 0, "R10 refill");
    settle_read();
    check("R10 count 120 no stall", int'(stall), 0);
    apply(9, 0, "R2 edge");
    settle_read();
    check("R10 count 129 stalls", int'(stall), 1);
    apply(4, 4, "R1 balanced");
    settle_read();
    check("R1 balanced keeps stall", int'(stall), 1);

    // R3: reset mid-run
    do_reset();
    @(negedge clk);
    check("R3 rerun limit", int'(limit), WINDOW);
    check("R3 rerun stall", int'(stall), 0);

    // R5/R6: search from INIT and settle where loss is acceptable
    begin
      bit seen_init = 0;
      for (int i = 0; i < 2000 && m_phase != 2; i++) begin
        step(1, "R6 search");
        if (m_phase == 1 && m_limit == INIT) seen_init = 1;
      end
      check("R5 cap began at INIT", int'(seen_init), 1);
    end
    settle_read();
    check("R6 settled cap", int'(limit), 64);

    // R9: stable IPC keeps the cap
    for (int i = 0; i < 3 * INTERVAL / 4; i++) step(1, "R9 hold");
    settle_read();
    check("R9 cap unchanged", int'(limit), 64);
    check("R9 still holding", m_phase, 2);

    // R8: IPC drop restarts the search
    for (int i = 0; i < 2000 && m_phase != 0; i++) step(2, "R8 drift down");
    settle_read();
    check("R8 restart cap", int'(limit), WINDOW);
    for (int i = 0; i < 2000 && m_phase != 2; i++) step(2, "R6 low ipc");
    settle_read();
    check("R6 settles at INIT", int'(limit), INIT);
    for (int i = 0; i < 4 * INTERVAL; i++) step(2, "R9 long hold");
    settle_read();
    check("R9 long hold cap", int'(limit), INIT);

    // R8 upward drift, then R7 saturation
    for (int i = 0; i < 2000 && m_phase != 0; i++) step(3, "R8 drift up");
    settle_read();
    check("R8 upward restart", int'(limit), WINDOW);
    for (int i = 0; i < 4000 && m_phase != 2; i++) step(3, "R7 saturate");
    settle_read();
    check("R7 saturated cap", int'(limit), WINDOW);

    @(negedge clk);
    fetch_cnt = '0; commit_cnt = '0;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule